// File: doc/BRIEF.md
# PCI Host Bridge Control Registers

This block is the control-register front end of a simple PCI host bridge. A processor reaches it over a 32-bit register bus that only carries whole aligned words. Through that bus the processor sees four things:

- a local copy of the bridge's own 256-byte configuration header;
- an address register for indirect configuration cycles;
- base registers for the memory window and the I/O window;
- a data port.

Each data-port access becomes exactly one 32-bit configuration transaction on a request/acknowledge interface toward the PCI side. The register bus is stalled until that transaction is acknowledged.

The block also has two pieces of combinational logic beside the registers. The first translates offsets inside a fixed 256 KB I/O aperture into PCI I/O addresses, using the upper bits of the I/O base register. The second routes device interrupts onto four outputs, choosing the output by each device's slot number.

Top module: `pci_hb_regs`

## Requirements
- R1: After reset, the configuration address, memory base and I/O base registers read zero. Header word 1 (offset 0x004, command in bits 15:0, status in bits 31:16) reads 0x0290_0080: command wait-cycle bit 7 set; status bits 4 (capability list), 7 (fast back-to-back) and 9 (medium device-select timing) set. All other header words read zero.
- R2: Offsets 0x000 to 0x0FC each hold one 32-bit header word, selected by address bits 7:2. A write stores all 32 bits, and a read returns them.
- R3: Offset 0x1C0 holds the configuration address. All 32 bits are stored and read back unchanged.
- R4: Offset 0x1C4 holds the memory base. A write keeps only the bits under mask 0xFF00_0001, and every other bit reads zero.
- R5: Offset 0x1C8 holds the I/O base. A write keeps only the bits under mask 0xFFFC_0001, and every other bit reads zero.
- R6: A write to offset 0x220 raises `cfg_req` with `cfg_wr`=1. It presents `cfg_addr` equal to the configuration address register and `cfg_wdata` equal to the written word. `bus_ready` stays low until the cycle in which `cfg_ack` is high.
- R7: A read of offset 0x220 raises `cfg_req` with `cfg_wr`=0 and completes in the `cfg_ack` cycle, with `bus_rdata` equal to `cfg_rdata`.
- R8: `cfg_req` stays high with a stable address until `cfg_ack`. It is low in the cycle after `cfg_ack`, and each data-port access issues exactly one request.
- R9: Reads of any undecoded word offset return zero, and writes to them change no register.
- R10: An access whose byte enables are not 4'b1111, or whose address bits 1:0 are not zero, completes at once with `bus_err`=1. It changes no state and issues no configuration request.
- R11: `io_pci_addr` equals (I/O base AND 0xFFFC_0000) plus the 18-bit `io_off`.
- R12: `irq_out[k]` is the OR of every `dev_irq[d]` whose 2-bit slot field `dev_slot[2d+1:2d]` equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the register window |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Rejected access size or alignment |
| cfg_req | output | 1 | Configuration transaction pending |
| cfg_wr | output | 1 | Configuration write (1) or read (0) |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | PCI side completes the transaction |
| cfg_rdata | input | 32 | Configuration read data, valid with ack |
| io_off | input | 18 | Offset inside the I/O aperture |
| io_pci_addr | output | 32 | Translated PCI I/O address |
| dev_irq | input | 4 | Device interrupt requests |
| dev_slot | input | 8 | Slot number of each device, 2 bits each |
| irq_out | output | 4 | Interrupts by slot |

## Verification
Several properties are checked on every cycle. The request/acknowledge protocol is one: a held request, a stable address and data, and no request in the cycle after an acknowledge. The others are that a data-port access never completes without an acknowledge, that malformed accesses are rejected at once, that the masked bits of both base registers read zero, and that the I/O translation holds.

Register contents are a different matter. Their persistence, the reset header words, and the claim that undecoded or rejected writes leave every register untouched can only be shown by the bench's read-back sequences. The same holds for the exact address and data that reach the PCI side for each data-port access, and for interrupt routing under varied slot assignments.

// File: rtl/pci_hb_regs.sv
module pci_hb_regs #(
  parameter int AW    = 10,
  parameter int NDEV  = 4,
  parameter int NSLOT = 4,
  parameter int IOW   = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [AW-1:0]               bus_addr,
  input  logic [3:0]                  bus_be,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_ready,
  output logic                        bus_err,
  output logic                        cfg_req,
  output logic                        cfg_wr,
  output logic [31:0]                 cfg_addr,
  output logic [31:0]                 cfg_wdata,
  input  logic                        cfg_ack,
  input  logic [31:0]                 cfg_rdata,
  input  logic [IOW-1:0]              io_off,
  output logic [31:0]                 io_pci_addr,
  input  logic [NDEV-1:0]             dev_irq,
  input  logic [NDEV*$clog2(NSLOT)-1:0] dev_slot,
  output logic [NSLOT-1:0]            irq_out
);
  localparam int SW   = $clog2(NSLOT);
  localparam int HDRW = 64;
  localparam logic [31:0] MEM_MASK = 32'hFF00_0001;
  localparam logic [31:0] IO_MASK  = 32'hFFFC_0001;
  localparam logic [31:0] HDR1_RST = 32'h0290_0080;
  localparam logic [AW-1:0] A_CAR = AW'(32'h1C0);
  localparam logic [AW-1:0] A_MEM = AW'(32'h1C4);
  localparam logic [AW-1:0] A_IO  = AW'(32'h1C8);
  localparam logic [AW-1:0] A_DP  = AW'(32'h220);
  localparam logic [AW-1:0] A_HDR_END = AW'(32'h100);

  logic [31:0] hdr [HDRW];
  logic [31:0] car_q, mem_q, io_q, wd_q;
  logic        pend_q, wr_q;

  wire acc_ok  = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire hit_hdr = bus_addr < A_HDR_END;
  wire is_dp   = acc_ok && (bus_addr == A_DP);
  wire wr_en   = bus_sel && bus_wr && acc_ok && !is_dp;
  wire [5:0] hidx = bus_addr[7:2];

  assign bus_err   = bus_sel && !acc_ok;
  assign bus_ready = bus_sel && (!is_dp || (pend_q && cfg_ack));
  assign cfg_req   = pend_q;
  assign cfg_wr    = wr_q;
  assign cfg_addr  = car_q;
  assign cfg_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDRW; i++) hdr[i] <= (i == 1) ? HDR1_RST : 32'h0;
      car_q <= '0;
      mem_q <= '0;
      io_q  <= '0;
    end else if (wr_en) begin
      if (hit_hdr) hdr[hidx] <= bus_wdata;
      if (bus_addr == A_CAR) car_q <= bus_wdata;
      if (bus_addr == A_MEM) mem_q <= bus_wdata & MEM_MASK;
      if (bus_addr == A_IO)  io_q  <= bus_wdata & IO_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
    end else if (pend_q) begin
      if (cfg_ack) pend_q <= 1'b0;
    end else if (bus_sel && is_dp) begin
      pend_q <= 1'b1;
      wr_q   <= bus_wr;
      wd_q   <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && acc_ok && !bus_wr) begin
      if (hit_hdr)                bus_rdata = hdr[hidx];
      else if (bus_addr == A_CAR) bus_rdata = car_q;
      else if (bus_addr == A_MEM) bus_rdata = mem_q;
      else if (bus_addr == A_IO)  bus_rdata = io_q;
      else if (bus_addr == A_DP)  bus_rdata = cfg_rdata;
    end
  end

  assign io_pci_addr = {io_q[31:IOW], {IOW{1'b0}}} + 32'(io_off);

  always_comb begin
    irq_out = '0;
    for (int k = 0; k < NSLOT; k++)
      for (int d = 0; d < NDEV; d++)
        if (dev_slot[d*SW +: SW] == SW'(k)) irq_out[k] = irq_out[k] | dev_irq[d];
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_wr));
  // R8
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> !cfg_req);
  // R6
  dp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready && !bus_err && bus_addr == A_DP |-> cfg_ack && cfg_req);
  // R10
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_be != 4'hF |-> bus_ready && bus_err && bus_rdata == 32'h0);
  // R10
  bad_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req && bus_err |=> !cfg_req);
  // R4
  mem_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && !bus_err && bus_addr == A_MEM |-> (bus_rdata & ~MEM_MASK) == 32'h0);
  // R5
  io_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && !bus_err && bus_addr == A_IO |-> (bus_rdata & ~IO_MASK) == 32'h0);
  // R11
  io_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_pci_addr[IOW-1:0] == io_off);
endmodule

// File: tb/pci_hb_regs_tb.sv
module pci_hb_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ready, bus_err;
  logic cfg_req, cfg_wr, cfg_ack = 0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = 0;
  logic [17:0] io_off = 0;
  logic [31:0] io_pci_addr;
  logic [3:0] dev_irq = 0, irq_out;
  logic [7:0] dev_slot = 0;

  int total = 0, bad = 0, nreq = 0, dly = 0;
  logic last_wr;
  logic [31:0] last_addr, last_wd;
  logic [31:0] hdr_m [64];
  logic [31:0] car_m, mem_m, io_m;

  always #2 clk = ~clk;

  pci_hb_regs dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] resp(input logic [31:0] a);
    return a ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    if (a < 10'h100) return hdr_m[a[7:2]];
    if (a == 10'h1C0) return car_m;
    if (a == 10'h1C4) return mem_m;
    if (a == 10'h1C8) return io_m;
    if (a == 10'h220) return resp(car_m);
    return 32'h0;
  endfunction

  task automatic model_wr(input logic [9:0] a, input logic [31:0] d);
    if (a < 10'h100) hdr_m[a[7:2]] = d;
    else if (a == 10'h1C0) car_m = d;
    else if (a == 10'h1C4) mem_m = d & 32'hFF00_0001;
    else if (a == 10'h1C8) io_m = d & 32'hFFFC_0001;
  endtask

  // PCI-side responder: random delay, one-cycle ack
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_ack) begin
        cfg_ack = 0;
        #1;
        // R8: no request in the cycle after ack
        chk(cfg_req == 0, "R8 gap", 32'(cfg_req), 0);
      end else if (cfg_req) begin
        if (dly == 0) begin
          cfg_ack = 1;
          cfg_rdata = resp(cfg_addr);
          last_wr = cfg_wr; last_addr = cfg_addr; last_wd = cfg_wdata;
          nreq++;
          dly = $urandom % 4;
        end else dly--;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [9:0] a, input logic [3:0] be, input logic [31:0] wd,
                      output logic [31:0] rd, output bit er, output int stall);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    stall = 0;
    #1;
    while (!bus_ready) begin
      stall++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata; er = bus_err;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic do_acc(input bit wr, input logic [9:0] a, input logic [31:0] wd, input string rq);
    logic [31:0] rd, e; bit er; int st, n0;
    n0 = nreq;
    e = exp_rd(a);
    xfer(wr, a, 4'hF, wd, rd, er, st);
    chk(!er, rq, 32'(er), 0);
    if (a == 10'h220) begin
      chk(nreq == n0 + 1 && st >= 1, wr ? "R6 one req/stall" : "R7 one req/stall", 32'(nreq - n0), 1);
      chk(last_addr == car_m && last_wr == wr, wr ? "R6 addr" : "R7 addr", last_addr, car_m);
      if (wr) chk(last_wd == wd, "R6 data", last_wd, wd);
      else chk(rd == e, "R7 rdata", rd, e);
    end else if (wr) model_wr(a, wd);
    else chk(rd == e, rq, rd, e);
  endtask

  function automatic logic [9:0] undec_addr();
    logic [9:0] a;
    do a = {($urandom % 192) + 64, 2'b00}[9:0];
    while (a == 10'h1C0 || a == 10'h1C4 || a == 10'h1C8 || a == 10'h220);
    return a;
  endfunction

  initial begin
    void'($urandom(32'd7321));
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    for (int i = 0; i < 64; i++) hdr_m[i] = (i == 1) ? 32'h0290_0080 : 32'h0;
    car_m = 0; mem_m = 0; io_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    do_acc(0, 10'h004, 0, "R1 hdr1");
    do_acc(0, 10'h000, 0, "R1 hdr0");
    do_acc(0, 10'h1C0, 0, "R1 car");
    do_acc(0, 10'h1C4, 0, "R1 mem");
    do_acc(0, 10'h1C8, 0, "R1 io");
    #1 chk(io_pci_addr == 0, "R1 io xlat", io_pci_addr, 0);
    // directed
    do_acc(1, 10'h0FC, 32'hDEAD_BEEF, "R2 wr");
    do_acc(0, 10'h0FC, 0, "R2 top word");
    do_acc(1, 10'h1C0, 32'hFFFF_FFFF, "R3 wr");
    do_acc(0, 10'h1C0, 0, "R3 all ones");
    do_acc(1, 10'h1C4, 32'hFFFF_FFFF, "R4 wr");
    do_acc(0, 10'h1C4, 0, "R4 mask");
    do_acc(1, 10'h1C8, 32'hFFFF_FFFF, "R5 wr");
    do_acc(0, 10'h1C8, 0, "R5 mask");
    do_acc(1, 10'h220, 32'h1234_5678, "R6");
    do_acc(0, 10'h220, 0, "R7");
    // R9 undecoded write then read back decoded regs
    do_acc(1, 10'h1CC, 32'hFFFF_FFFF, "R9 wr");
    do_acc(1, 10'h3FC, 32'hFFFF_FFFF, "R9 wr");
    do_acc(0, 10'h1CC, 0, "R9 undecoded read");
    do_acc(0, 10'h1C0, 0, "R9 car kept");
    do_acc(0, 10'h1C4, 0, "R9 mem kept");
    do_acc(0, 10'h1C8, 0, "R9 io kept");
    // R10 bad accesses
    begin
      logic [31:0] rd; bit er; int st, n0;
      n0 = nreq;
      xfer(1, 10'h220, 4'h3, 32'h1, rd, er, st);
      chk(er && st == 0 && nreq == n0, "R10 dp half", 32'(er), 1);
      xfer(1, 10'h1C2, 4'hF, 32'h0, rd, er, st);
      chk(er && st == 0, "R10 misaligned", 32'(er), 1);
      xfer(1, 10'h1C0, 4'h1, 32'h0, rd, er, st);
      chk(er, "R10 byte", 32'(er), 1);
      repeat (3) @(negedge clk);
      chk(nreq == n0, "R10 no req", nreq, n0);
      do_acc(0, 10'h1C0, 0, "R10 car kept");
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      int s; logic [9:0] a; bit wr;
      s = $urandom % 6; wr = $urandom % 2;
      case (s)
        0: a = {2'b00, 6'($urandom % 64), 2'b00};
        1: a = 10'h1C0;
        2: a = 10'h1C4;
        3: a = 10'h1C8;
        4: a = 10'h220;
        default: a = undec_addr();
      endcase
      do_acc(wr, a, $urandom, a < 10'h100 ? "R2 rand" : s == 1 ? "R3 rand" : s == 2 ? "R4 rand" :
             s == 3 ? "R5 rand" : s == 4 ? "R6 rand" : "R9 rand");
      if (i % 8 == 0) begin
        logic [31:0] e;
        io_off = 18'($urandom);
        e = (io_m & 32'hFFFC_0000) + 32'(io_off);
        @(negedge clk); #1;
        chk(io_pci_addr == e, "R11 xlat", io_pci_addr, e);
      end
    end
    // R12 interrupt routing
    for (int i = 0; i < 40; i++) begin
      logic [3:0] e;
      dev_irq = 4'($urandom); dev_slot = 8'($urandom);
      if (i == 0) begin dev_irq = 4'hF; dev_slot = 8'hFF; end
      e = 0;
      for (int d = 0; d < 4; d++) if (dev_irq[d]) e[dev_slot[2*d +: 2]] = 1;
      #1;
      chk(irq_out == e, "R12 route", 32'(irq_out), 32'(e));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule